// File: doc/BRIEF.md
# Program-Controlled I/O Bus Device Controller

This block is the device end of a shared parallel I/O bus that a processor drives under program control. The processor puts a 10-bit code on the address bus. The low 6 bits name a device and the upper 4 bits carry a function code. The processor then issues one of four command kinds:

- a control pulse, which carries no data;
- a status sense;
- a word input;
- a word output.

The controller answers sense, input and output commands on one reply line. The reply line is driven from a ready flip-flop or from a condition that the function code selects. The processor reads a missing reply as "skip not taken". When the processor accepts an input word, it clears ready with a separate reset-ready pulse. When it sends an output word, an output strobe loads the output bus into the device buffer.

The controller also holds a set of mode bits that control pulses set and clear, and an interrupt mask bit that a broadcast set-mask pulse loads from the output bus. It raises an interrupt request while ready is set, the mask allows it, and the request has not yet been polled. A system-normalize input returns the control state to idle. All signals here are active-high, and any bus-level inversion belongs to a wrapper. Each bus pulse is one clock cycle long, and every register update becomes visible in the cycle after the edge that samples it.

Top module: `iobus_dev_ctrl`

## Requirements
- R1: A command is addressed only when `adr_vld` is high and the low 6 bits of `adr_bus` equal `DEV_ADDR` (default 23). Otherwise `reply` and `in_bus` stay 0, and the ready, mode and mask state are unchanged by control pulses, reset-ready pulses and output strobes.
- R2: An addressed control pulse acts on mode bit k, where k is function bits [2:0]. With function bit 3 at 0 (codes 0 to 3) it sets bit k. With function bit 3 at 1 (codes 8 to 11) it clears bit k. The mode bits appear on `mode_o` in the next cycle.
- R3: While addressed, `reply` equals the condition that the function code selects: 0 selects ready, 1 selects not ready, 2 selects ready AND mask, 8 + k selects mode bit k. Every other code gives 0. The reply is combinational in the same cycle.
- R4: `in_bus` carries the held input word only while the controller is addressed with function code 0 and ready is set. Otherwise `in_bus` is all zeros.
- R5: A `dev_ready_set` pulse sets ready and captures `dev_in_data` as the held input word. Both take effect in the next cycle.
- R6: An addressed `rdy_clr_pulse` clears ready in the next cycle.
- R7: An addressed `out_strobe` does three things in the next cycle: `out_buf_o` holds the `out_bus` word, ready is clear, and `out_load_o` is high for exactly that one cycle.
- R8: A `mask_pulse` loads `out_bus` bit 0 into the mask flip-flop whether or not the device is addressed.
- R9: `irq` is high exactly when ready AND mask AND NOT serviced are all true. Serviced is set by an addressed sense with code 2 while ready and mask are both set. It clears once ready has been seen clear.
- R10: `sys_norm` clears ready, mask, serviced and all mode bits in the next cycle.
- R11: If `dev_ready_set` arrives in the same cycle as a clearing pulse (reset-ready or output strobe), ready ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_norm | input | 1 | Synchronous system normalize |
| adr_bus | input | 10 | Function code [9:6], device address [5:0] |
| adr_vld | input | 1 | Address bus holds a valid code |
| ctl_pulse | input | 1 | Control command pulse |
| rdy_clr_pulse | input | 1 | Reset-ready pulse after input accepted |
| out_strobe | input | 1 | Output data strobe |
| mask_pulse | input | 1 | Broadcast set-mask pulse |
| out_bus | input | 16 | Output data bus from processor |
| dev_ready_set | input | 1 | Peripheral event: data/space available |
| dev_in_data | input | 16 | Peripheral input word |
| reply | output | 1 | Reply line to processor |
| in_bus | output | 16 | Input data bus to processor (zero when idle) |
| irq | output | 1 | Interrupt request |
| mode_o | output | 4 | Mode bits to peripheral |
| out_buf_o | output | 16 | Output data buffer to peripheral |
| out_load_o | output | 1 | One-cycle pulse after buffer load |

## Verification
The bench sends each command kind with a foreign address and with `adr_vld` low. A decoder that ignored either qualifier would raise the reply or change ready. It drives a set and a clear of ready in the same cycle; a design with the wrong priority would lose the peripheral event and report not-ready. It polls the interrupt condition and then cycles ready. This exposes a serviced flag that never clears, which would leave the request dead, or one that is never set, which would leave the request stuck high. It checks that normalize clears the mask by raising ready afterwards and watching `irq` stay low. Further cases are an input-bus read under a non-read function code, which must give zeros, and the one-cycle width of the buffer-load pulse.

// File: rtl/iobus_pkg.sv
package iobus_pkg;
   // Function codes in the lower bank (function MSB = 0) used for sense/read
   localparam int FN_SENSE_READY = 0;  // also the code for word input / output
   localparam int FN_SENSE_BUSY  = 1;
   localparam int FN_SENSE_IRQ   = 2;

   // Field placement on the address bus
   typedef enum logic {
      FIELD_FUNC_HIGH = 1'b1,
      FIELD_FUNC_LOW  = 1'b0
   } field_order_e;
endpackage

// File: rtl/iobus_addr_decode.sv
module iobus_addr_decode
   import iobus_pkg::*;
#(
   parameter int                  FUNC_W     = 4,
   parameter int                  DEV_W      = 6,
   parameter logic [DEV_W-1:0]    DEV_ADDR   = 6'd23,
   parameter field_order_e        FIELD_ORDER = FIELD_FUNC_HIGH,
   localparam int                 ADR_W      = FUNC_W + DEV_W,
   localparam int                 IDX_W      = FUNC_W - 1
) (
   input  logic [ADR_W-1:0] adr_bus,
   input  logic             adr_vld,
   input  logic             ctl_pulse,
   input  logic             rdy_clr_pulse,
   input  logic             out_strobe,
   output logic             hit,
   output logic             ctl_hit,
   output logic             clr_hit,
   output logic             stb_hit,
   output logic             func_hi,
   output logic [IDX_W-1:0] func_idx
);
   logic [FUNC_W-1:0] func_f;
   logic [DEV_W-1:0]  dev_f;

   generate
      if (FIELD_ORDER == FIELD_FUNC_HIGH) begin : g_func_high
         assign func_f = adr_bus[ADR_W-1:DEV_W];
         assign dev_f  = adr_bus[DEV_W-1:0];
      end else begin : g_func_low
         assign func_f = adr_bus[FUNC_W-1:0];
         assign dev_f  = adr_bus[ADR_W-1:FUNC_W];
      end
   endgenerate

   always_comb begin
      hit      = adr_vld && (dev_f == DEV_ADDR);
      ctl_hit  = hit && ctl_pulse;
      clr_hit  = hit && rdy_clr_pulse;
      stb_hit  = hit && out_strobe;
      func_hi  = func_f[FUNC_W-1];
      func_idx = func_f[IDX_W-1:0];
   end

   // Qualified pulses can only exist while the device is addressed
   always_comb begin
      AST_PULSE_NEEDS_HIT : assert (!(ctl_hit || clr_hit || stb_hit) || hit); // R1
   end
endmodule

// File: rtl/iobus_status.sv
module iobus_status
   import iobus_pkg::*;
#(
   parameter  int FUNC_W = 4,
   parameter  int MODE_W = 4,
   localparam int IDX_W  = FUNC_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sys_norm,
   input  logic              hit,
   input  logic              ctl_hit,
   input  logic              clr_hit,
   input  logic              stb_hit,
   input  logic              func_hi,
   input  logic [IDX_W-1:0]  func_idx,
   input  logic              mask_pulse,
   input  logic              mask_din,
   input  logic              dev_ready_set,
   output logic              ready,
   output logic              mask_en,
   output logic [MODE_W-1:0] mode,
   output logic              irq
);
   logic serviced;
   logic irq_poll;

   assign irq_poll = hit && !func_hi && (func_idx == IDX_W'(FN_SENSE_IRQ))
                     && ready && mask_en;

   // Ready flip-flop: normalize first, then a peripheral set beats any clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ready <= 1'b0;
      else if (sys_norm)       ready <= 1'b0;
      else if (dev_ready_set)  ready <= 1'b1;
      else if (clr_hit || stb_hit) ready <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mask_en <= 1'b0;
      else if (sys_norm)   mask_en <= 1'b0;
      else if (mask_pulse) mask_en <= mask_din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         serviced <= 1'b0;
      else if (sys_norm)  serviced <= 1'b0;
      else if (!ready)    serviced <= 1'b0;
      else if (irq_poll)  serviced <= 1'b1;
   end

   assign irq = ready && mask_en && !serviced;

   genvar k;
   generate
      for (k = 0; k < MODE_W; k++) begin : g_mode
         logic set_k, clr_k;
         assign set_k = ctl_hit && !func_hi && (func_idx == IDX_W'(k));
         assign clr_k = ctl_hit &&  func_hi && (func_idx == IDX_W'(k));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        mode[k] <= 1'b0;
            else if (sys_norm) mode[k] <= 1'b0;
            else if (set_k)    mode[k] <= 1'b1;
            else if (clr_k)    mode[k] <= 1'b0;
         end
      end
   endgenerate

   AST_SET_BEATS_CLEAR : assert property (@(posedge clk) disable iff (!rst_n)
      (dev_ready_set && !sys_norm) |=> ready); // R11
   AST_RESET_READY : assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && !dev_ready_set) |=> !ready); // R6
   AST_NORMALIZE : assert property (@(posedge clk) disable iff (!rst_n)
      sys_norm |=> (!ready && !mask_en && (mode == '0))); // R10
   AST_IRQ_GATED : assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ready && mask_en)); // R9
   AST_MASK_LOAD : assert property (@(posedge clk) disable iff (!rst_n)
      (mask_pulse && !sys_norm) |=> (mask_en == $past(mask_din))); // R8
   AST_MODE0_SET : assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_hit && !func_hi && (func_idx == '0) && !sys_norm) |=> mode[0]); // R2
   AST_FOREIGN_MODE_HOLD : assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && !sys_norm) |=> $stable(mode)); // R1
endmodule

// File: rtl/iobus_data_path.sv
module iobus_data_path
   import iobus_pkg::*;
#(
   parameter  int FUNC_W          = 4,
   parameter  int MODE_W          = 4,
   parameter  int DATA_W          = 16,
   parameter  bit IN_GATE_BY_FUNC = 1'b1,
   localparam int IDX_W           = FUNC_W - 1,
   localparam int BANK            = 2 ** IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic              stb_hit,
   input  logic              func_hi,
   input  logic [IDX_W-1:0]  func_idx,
   input  logic              ready,
   input  logic              mask_en,
   input  logic [MODE_W-1:0] mode,
   input  logic              dev_ready_set,
   input  logic [DATA_W-1:0] dev_in_data,
   input  logic [DATA_W-1:0] out_bus,
   output logic              reply,
   output logic [DATA_W-1:0] in_bus,
   output logic [DATA_W-1:0] out_buf,
   output logic              out_load
);
   logic [DATA_W-1:0] in_hold;
   logic [BANK-1:0]   lo_cond;
   logic [BANK-1:0]   hi_cond;
   logic              drive_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             in_hold <= '0;
      else if (dev_ready_set) in_hold <= dev_in_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_buf  <= '0;
         out_load <= 1'b0;
      end else begin
         out_load <= stb_hit;
         if (stb_hit) out_buf <= out_bus;
      end
   end

   genvar i;
   generate
      for (i = 0; i < BANK; i++) begin : g_cond
         if (i == FN_SENSE_READY) begin : g_rdy
            assign lo_cond[i] = ready;
         end else if (i == FN_SENSE_BUSY) begin : g_busy
            assign lo_cond[i] = !ready;
         end else if (i == FN_SENSE_IRQ) begin : g_pend
            assign lo_cond[i] = ready && mask_en;
         end else begin : g_lo_none
            assign lo_cond[i] = 1'b0;
         end
         if (i < MODE_W) begin : g_mode_sense
            assign hi_cond[i] = mode[i];
         end else begin : g_hi_none
            assign hi_cond[i] = 1'b0;
         end
      end

      if (IN_GATE_BY_FUNC) begin : g_gate_func
         assign drive_in = hit && ready && !func_hi
                           && (func_idx == IDX_W'(FN_SENSE_READY));
      end else begin : g_gate_any
         assign drive_in = hit && ready;
      end
   endgenerate

   assign reply  = hit && (func_hi ? hi_cond[func_idx] : lo_cond[func_idx]);
   assign in_bus = drive_in ? in_hold : '0;

   AST_QUIET_FOREIGN : assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (!reply && (in_bus == '0))); // R1
   AST_IN_NEEDS_READY : assert property (@(posedge clk) disable iff (!rst_n)
      (in_bus != '0) |-> ready); // R4
   AST_STROBE_LOAD : assert property (@(posedge clk) disable iff (!rst_n)
      stb_hit |=> (out_load && (out_buf == $past(out_bus)))); // R7
   AST_LOAD_ONE_CYCLE : assert property (@(posedge clk) disable iff (!rst_n)
      (out_load && !stb_hit) |=> !out_load); // R7
   AST_HOLD_CAPTURE : assert property (@(posedge clk) disable iff (!rst_n)
      (dev_ready_set && hit && !func_hi && (func_idx == '0)) |=>
         (!IN_GATE_BY_FUNC || !hit || func_hi || (func_idx != '0) || !ready
          || (in_bus == $past(dev_in_data)))); // R5
endmodule

// File: rtl/iobus_dev_ctrl.sv
module iobus_dev_ctrl
   import iobus_pkg::*;
#(
   parameter  int                FUNC_W          = 4,
   parameter  int                DEV_W           = 6,
   parameter  logic [DEV_W-1:0]  DEV_ADDR        = 6'd23,
   parameter  int                DATA_W          = 16,
   parameter  int                MODE_W          = 4,
   parameter  int                MASK_BIT        = 0,
   parameter  bit                IN_GATE_BY_FUNC = 1'b1,
   parameter  field_order_e      FIELD_ORDER     = FIELD_FUNC_HIGH,
   localparam int                ADR_W           = FUNC_W + DEV_W,
   localparam int                IDX_W           = FUNC_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sys_norm,
   input  logic [ADR_W-1:0]  adr_bus,
   input  logic              adr_vld,
   input  logic              ctl_pulse,
   input  logic              rdy_clr_pulse,
   input  logic              out_strobe,
   input  logic              mask_pulse,
   input  logic [DATA_W-1:0] out_bus,
   input  logic              dev_ready_set,
   input  logic [DATA_W-1:0] dev_in_data,
   output logic              reply,
   output logic [DATA_W-1:0] in_bus,
   output logic              irq,
   output logic [MODE_W-1:0] mode_o,
   output logic [DATA_W-1:0] out_buf_o,
   output logic              out_load_o
);
   generate
      if (FUNC_W < 3)               begin : g_bad_func  $error("FUNC_W must be at least 3"); end
      if (DEV_W < 1)                begin : g_bad_dev   $error("DEV_W must be positive"); end
      if (MODE_W < 1 || MODE_W > 2 ** (FUNC_W - 1))
                                    begin : g_bad_mode  $error("MODE_W exceeds function bank"); end
      if (MASK_BIT < 0 || MASK_BIT >= DATA_W)
                                    begin : g_bad_mask  $error("MASK_BIT outside data bus"); end
   endgenerate

   logic             hit, ctl_hit, clr_hit, stb_hit, func_hi;
   logic [IDX_W-1:0] func_idx;
   logic             ready, mask_en;

   iobus_addr_decode #(
      .FUNC_W(FUNC_W), .DEV_W(DEV_W), .DEV_ADDR(DEV_ADDR), .FIELD_ORDER(FIELD_ORDER)
   ) u_decode (
      .adr_bus(adr_bus), .adr_vld(adr_vld), .ctl_pulse(ctl_pulse),
      .rdy_clr_pulse(rdy_clr_pulse), .out_strobe(out_strobe),
      .hit(hit), .ctl_hit(ctl_hit), .clr_hit(clr_hit), .stb_hit(stb_hit),
      .func_hi(func_hi), .func_idx(func_idx)
   );

   iobus_status #(.FUNC_W(FUNC_W), .MODE_W(MODE_W)) u_status (
      .clk(clk), .rst_n(rst_n), .sys_norm(sys_norm), .hit(hit),
      .ctl_hit(ctl_hit), .clr_hit(clr_hit), .stb_hit(stb_hit),
      .func_hi(func_hi), .func_idx(func_idx),
      .mask_pulse(mask_pulse), .mask_din(out_bus[MASK_BIT]),
      .dev_ready_set(dev_ready_set),
      .ready(ready), .mask_en(mask_en), .mode(mode_o), .irq(irq)
   );

   iobus_data_path #(
      .FUNC_W(FUNC_W), .MODE_W(MODE_W), .DATA_W(DATA_W), .IN_GATE_BY_FUNC(IN_GATE_BY_FUNC)
   ) u_data (
      .clk(clk), .rst_n(rst_n), .hit(hit), .stb_hit(stb_hit),
      .func_hi(func_hi), .func_idx(func_idx), .ready(ready), .mask_en(mask_en),
      .mode(mode_o), .dev_ready_set(dev_ready_set), .dev_in_data(dev_in_data),
      .out_bus(out_bus), .reply(reply), .in_bus(in_bus),
      .out_buf(out_buf_o), .out_load(out_load_o)
   );

   AST_STROBE_DROPS_READY : assert property (@(posedge clk) disable iff (!rst_n)
      (stb_hit && !dev_ready_set) |=> !ready); // R7
   AST_SET_READY : assert property (@(posedge clk) disable iff (!rst_n)
      (dev_ready_set && !sys_norm) |=> ready); // R5
endmodule

// File: tb/tb_iobus_dev_ctrl.sv
module tb_iobus_dev_ctrl;
   localparam int CLK_P = 10;
   localparam logic [5:0] MY_DEV  = 6'd23;
   localparam logic [5:0] OTH_DEV = 6'd5;

   logic        clk = 1'b0;
   logic        rst_n, sys_norm, adr_vld, ctl_pulse, rdy_clr_pulse, out_strobe, mask_pulse;
   logic [9:0]  adr_bus;
   logic [15:0] out_bus, dev_in_data, in_bus, out_buf_o;
   logic        dev_ready_set, reply, irq, out_load_o;
   logic [3:0]  mode_o;

   iobus_dev_ctrl dut (
      .clk(clk), .rst_n(rst_n), .sys_norm(sys_norm), .adr_bus(adr_bus), .adr_vld(adr_vld),
      .ctl_pulse(ctl_pulse), .rdy_clr_pulse(rdy_clr_pulse), .out_strobe(out_strobe),
      .mask_pulse(mask_pulse), .out_bus(out_bus), .dev_ready_set(dev_ready_set),
      .dev_in_data(dev_in_data), .reply(reply), .in_bus(in_bus), .irq(irq),
      .mode_o(mode_o), .out_buf_o(out_buf_o), .out_load_o(out_load_o)
   );

   always #(CLK_P/2) clk = ~clk;

   typedef enum int {F_REPLY, F_INBUS, F_IRQ, F_MODE, F_OBUF, F_OLOAD} field_e;
   typedef struct { string req; field_e fld; logic [31:0] exp; } item_t;
   item_t exp_q[$];
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   function automatic logic [31:0] observe(field_e f);
      case (f)
         F_REPLY: return 32'(reply);
         F_INBUS: return 32'(in_bus);
         F_IRQ:   return 32'(irq);
         F_MODE:  return 32'(mode_o);
         F_OBUF:  return 32'(out_buf_o);
         default: return 32'(out_load_o);
      endcase
   endfunction

   // Monitor: compares queued expectations against outputs, away from the edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (exp_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = exp_q.pop_front();
            act = observe(it.fld);
            n_chk++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s field %s: actual %h expected %h", it.req, it.fld.name(), act, it.exp);
            end
         end
      end
   end

   task automatic expect_v(string req, field_e f, logic [31:0] v);
      item_t it;
      it.req = req; it.fld = f; it.exp = v;
      exp_q.push_back(it);
   endtask

   // Drive one cycle of bus activity at the falling edge
   task automatic drv(input logic [3:0] fn, input logic [5:0] dev, input logic vld,
                      input logic ctl = 0, input logic clr = 0, input logic stb = 0,
                      input logic msk = 0, input logic nrm = 0, input logic set = 0,
                      input logic [15:0] obus = 16'h0, input logic [15:0] din = 16'h0);
      @(negedge clk);
      adr_bus = {fn, dev}; adr_vld = vld; ctl_pulse = ctl; rdy_clr_pulse = clr;
      out_strobe = stb; mask_pulse = msk; sys_norm = nrm; dev_ready_set = set;
      out_bus = obus; dev_in_data = din;
   endtask

   task automatic idle();
      drv(4'h0, 6'h0, 1'b0);
   endtask

   initial begin
      rst_n = 0; sys_norm = 0; adr_bus = '0; adr_vld = 0; ctl_pulse = 0;
      rdy_clr_pulse = 0; out_strobe = 0; mask_pulse = 0; out_bus = '0;
      dev_ready_set = 0; dev_in_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // Reset state (R10): not ready, no irq, modes clear
      drv(4'h0, MY_DEV, 1);
      expect_v("R10 reset ready", F_REPLY, 0);
      expect_v("R10 reset irq",   F_IRQ,   0);
      expect_v("R10 reset mode",  F_MODE,  0);
      expect_v("R7 reset load",   F_OLOAD, 0);
      expect_v("R4 reset inbus",  F_INBUS, 0);
      // Sense not-ready code 1 (R3)
      drv(4'h1, MY_DEV, 1);
      expect_v("R3 sense busy", F_REPLY, 1);
      // Foreign address (R1)
      drv(4'h1, OTH_DEV, 1);
      expect_v("R1 foreign sense", F_REPLY, 0);
      // Peripheral delivers word (R5)
      drv(4'h0, 6'h0, 0, .set(1), .din(16'hA5A5));
      drv(4'h0, MY_DEV, 1);
      expect_v("R5 ready set",   F_REPLY, 1);
      expect_v("R4 input word",  F_INBUS, 32'hA5A5);
      drv(4'h1, MY_DEV, 1);
      expect_v("R4 non-read code inbus", F_INBUS, 0);
      expect_v("R3 busy while ready",    F_REPLY, 0);
      drv(4'h0, MY_DEV, 0);
      expect_v("R1 vld low reply", F_REPLY, 0);
      expect_v("R1 vld low inbus", F_INBUS, 0);
      // Foreign reset-ready and reset-ready with vld low (R1)
      drv(4'h0, OTH_DEV, 1, .clr(1));
      drv(4'h0, MY_DEV, 0, .clr(1));
      drv(4'h0, MY_DEV, 1);
      expect_v("R1 foreign clear ignored", F_REPLY, 1);
      // Addressed reset-ready (R6)
      drv(4'h0, MY_DEV, 1, .clr(1));
      drv(4'h0, MY_DEV, 1);
      expect_v("R6 ready cleared", F_REPLY, 0);
      // Control pulses (R2)
      drv(4'h2, MY_DEV, 1, .ctl(1));
      drv(4'h0, MY_DEV, 1, .ctl(1));
      drv(4'hA, MY_DEV, 1, .ctl(1));
      expect_v("R2 set mode0 and 2", F_MODE, 4'b0101);
      idle();
      expect_v("R2 clear mode2", F_MODE, 4'b0001);
      drv(4'h1, OTH_DEV, 1, .ctl(1));
      drv(4'h8, MY_DEV, 1);
      expect_v("R1 foreign ctl", F_MODE, 4'b0001);
      expect_v("R3 sense mode0", F_REPLY, 1);
      drv(4'h9, MY_DEV, 1);
      expect_v("R3 sense mode1", F_REPLY, 0);
      drv(4'h5, MY_DEV, 1);
      expect_v("R3 unused code", F_REPLY, 0);
      // Mask and interrupt (R8, R9)
      drv(4'h0, OTH_DEV, 1, .msk(1), .set(1), .obus(16'h0001), .din(16'h1111));
      drv(4'h2, MY_DEV, 1);
      expect_v("R9 irq raised",   F_IRQ,   1);
      expect_v("R8 mask pending", F_REPLY, 1);
      drv(4'h2, MY_DEV, 1);
      expect_v("R9 irq serviced", F_IRQ,   0);
      expect_v("R3 pending still", F_REPLY, 1);
      drv(4'h0, MY_DEV, 1, .clr(1));
      idle();
      expect_v("R9 no ready no irq", F_IRQ, 0);
      drv(4'h0, 6'h0, 0, .set(1), .din(16'h2222));
      idle();
      expect_v("R9 irq re-armed", F_IRQ, 1);
      // Output strobe (R7)
      drv(4'h0, MY_DEV, 1, .stb(1), .obus(16'h1234));
      drv(4'h0, MY_DEV, 1);
      expect_v("R7 buffer", F_OBUF,  32'h1234);
      expect_v("R7 load",   F_OLOAD, 1);
      expect_v("R7 ready dropped", F_REPLY, 0);
      expect_v("R9 irq dropped", F_IRQ, 0);
      idle();
      expect_v("R7 load one cycle", F_OLOAD, 0);
      drv(4'h0, OTH_DEV, 1, .stb(1), .obus(16'hBEEF));
      idle();
      expect_v("R1 foreign strobe", F_OBUF, 32'h1234);
      expect_v("R1 foreign no load", F_OLOAD, 0);
      // Same-cycle set and clear (R11)
      drv(4'h0, MY_DEV, 1, .clr(1), .set(1), .din(16'h3333));
      drv(4'h0, MY_DEV, 1);
      expect_v("R11 set wins", F_REPLY, 1);
      expect_v("R5 new word",  F_INBUS, 32'h3333);
      // Normalize (R10)
      drv(4'h0, 6'h0, 0, .nrm(1));
      drv(4'h0, MY_DEV, 1, .set(1), .din(16'h4444));
      expect_v("R10 mode cleared",  F_MODE,  0);
      expect_v("R10 ready cleared", F_REPLY, 0);
      idle();
      expect_v("R10 mask cleared", F_IRQ, 0);
      drv(4'h0, MY_DEV, 1);
      expect_v("R5 ready after norm", F_REPLY, 1);

      idle();
      idle();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule